// File: doc/BRIEF.md
# Codec Serial Frame Port Controller

This block is the host-side end of a synchronous serial link to an audio codec. It counts serial clocks in fixed-length frames. It drives a frame-sync line and an outgoing data line, and it assembles words from an incoming data line on the same serial clocks. The fabric clock runs faster than the serial clock. A single-cycle `sclk_en` pulse marks each serial clock. The interval between two such pulses is one bit slot. Outgoing bits and the sync line change right after a pulse, which stands for the rising serial edge. The incoming bit of a slot is taken on the pulse that closes the slot, which stands for the falling edge.

Five configuration inputs choose the frame layout:
- mixed mode, where control and status words travel beside the samples, or data mode, where only samples travel;
- a host word grid of 16 or 32 bits;
- a sample width of 16 or 24 bits;
- a frame of 128 or 256 slots;
- an optional mode that adds extra sync marks at word intervals.

The settings are captured only when one frame ends and the next begins.

On the host side there are parallel words with strobes. The host supplies control and DAC words and receives status and ADC words. If the host supplies nothing new, the last DAC word is sent again and an all-zero control word goes out. If the host does not collect an ADC word before the next one arrives, the new word replaces it and a sticky overrun flag is raised. The frame timing never depends on the host.

Top module: `codec_frame_port`

## Requirements
- R1: With the extra-mark mode off, a frame is 128 slots (`cfg_fast`=0) or 256 slots (`cfg_fast`=1). Slots are numbered 0 upward. `fs_out` is high only in the last slot of each frame, the slot just before bit 0. After reset the block sits in the last slot of a 128-slot frame.
- R2: With `cfg_mfs`=1, `fs_out` is also high in every slot k where k mod G = G-1. G is 16 when `cfg_wide`=0 and 32 when `cfg_wide`=1.
- R3: In mixed mode (`cfg_mixed`=1), slots 0 to 15 carry the control word, most significant bit first. The DAC sample starts at slot G, MSB first, and lasts S slots. All other slots carry 0.
- R4: In data mode (`cfg_mixed`=0), the DAC sample occupies slots 0 to S-1, MSB first. No control word is sent and `sts_valid` never pulses.
- R5: S is 16 when `cfg_s24`=0 and 24 when `cfg_s24`=1. A 16-bit sample is taken from `dac_data[15:0]`. A received 16-bit sample appears on `adc_data[15:0]` with bits 23:16 at zero.
- R6: In mixed mode, the bits received in slots 0 to 15 form the status word, first bit as MSB. That word appears on `sts_data` with a one-cycle `sts_valid` pulse.
- R7: The bits received in the sample slots form the ADC word, first bit as MSB. After it is captured, `adc_valid` stays high and `adc_data` stays unchanged until `adc_rd` is pulsed.
- R8: A frame sends the DAC word most recently written through `dac_valid`, so an old word is sent again. It sends the control word written through `ctl_valid` during the previous frame, or all zeros if none was written.
- R9: Configuration inputs that change during a frame have no effect on that frame. The values present at the frame's last slot govern the next frame.
- R10: If an ADC word is captured while the previous one is still uncollected, the new word replaces it and `overrun` goes high. `overrun` then stays high until reset, and the frame timing is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low reset |
| sclk_en | input | 1 | One-cycle pulse per serial clock |
| cfg_mixed | input | 1 | 1 = mixed mode, 0 = data mode |
| cfg_wide | input | 1 | Host word grid: 0 = 16, 1 = 32 |
| cfg_s24 | input | 1 | Sample width: 0 = 16, 1 = 24 |
| cfg_fast | input | 1 | Frame length: 0 = 128, 1 = 256 slots |
| cfg_mfs | input | 1 | Extra sync marks at every word boundary |
| ctl_data | input | 16 | Control word for the next frame |
| ctl_valid | input | 1 | Write strobe for ctl_data |
| dac_data | input | 24 | DAC sample, right-aligned |
| dac_valid | input | 1 | Write strobe for dac_data |
| fs_out | output | 1 | Frame-sync line |
| sd_out | output | 1 | Outgoing serial data |
| sd_in | input | 1 | Incoming serial data |
| sts_data | output | 16 | Last received status word |
| sts_valid | output | 1 | One-cycle pulse on a new status word |
| adc_data | output | 24 | Last received ADC sample, right-aligned |
| adc_valid | output | 1 | ADC word present and not collected |
| adc_rd | input | 1 | Host collects the ADC word |
| overrun | output | 1 | Sticky: an uncollected ADC word was replaced |

## Verification
The hardest case to reach is a frame whose configuration inputs move partway through. The old layout must hold until the frame ends, and the new layout must then start exactly on slot 0, possibly with a different frame length. The stimulus changes the inputs at slot 10 of chosen frames and checks every slot of the current frame against the old layout. Skipped host reads are interleaved with these frames, so the overrun flag and the resent words are checked while the frame geometry changes. Serial-clock gaps are random, so no result depends on a fixed ratio between the fabric clock and the serial clock.

// File: rtl/codec_frame_port.sv
module codec_frame_port #(
  parameter int NORM_LEN = 128,
  parameter int FAST_LEN = 256,
  parameter int CTL_W    = 16,
  parameter int SMP_W    = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_en,
  input  logic             cfg_mixed,
  input  logic             cfg_wide,
  input  logic             cfg_s24,
  input  logic             cfg_fast,
  input  logic             cfg_mfs,
  input  logic [CTL_W-1:0] ctl_data,
  input  logic             ctl_valid,
  input  logic [SMP_W-1:0] dac_data,
  input  logic             dac_valid,
  output logic             fs_out,
  output logic             sd_out,
  input  logic             sd_in,
  output logic [CTL_W-1:0] sts_data,
  output logic             sts_valid,
  output logic [SMP_W-1:0] adc_data,
  output logic             adc_valid,
  input  logic             adc_rd,
  output logic             overrun
);
  localparam int CW = $clog2(FAST_LEN);
  localparam int IW = $clog2(SMP_W);

  logic [CW-1:0]    cnt;
  logic             m_q, w_q, s_q, f_q, mf_q;
  logic [CTL_W-1:0] ctl_q, ctl_p, sts_sr;
  logic             ctl_pv;
  logic [SMP_W-1:0] dac_q, dac_p, rx_sr;

  wire [CW-1:0] last = f_q ? CW'(FAST_LEN - 1) : CW'(NORM_LEN - 1);
  wire [CW-1:0] grid = w_q ? CW'(2 * CTL_W) : CW'(CTL_W);
  wire [CW-1:0] woff = m_q ? grid : '0;
  wire [CW-1:0] slen = s_q ? CW'(SMP_W) : CW'(CTL_W);
  wire [CW-1:0] rel  = cnt - woff;
  wire [CW-1:0] didx = slen - CW'(1) - rel;
  wire [CW-1:0] cidx = CW'(CTL_W - 1) - cnt;

  wire in_ctl   = m_q && (cnt < CW'(CTL_W));
  wire in_smp   = (cnt >= woff) && (rel < slen);
  wire boundary = sclk_en && (cnt == last);
  wire sts_end  = sclk_en && in_ctl && (cnt == CW'(CTL_W - 1));
  wire smp_end  = sclk_en && in_smp && (rel == slen - CW'(1));
  wire mark     = ((cnt + CW'(1)) & (grid - CW'(1))) == '0;

  assign fs_out = (cnt == last) || (mf_q && mark);
  assign sd_out = in_ctl ? ctl_q[cidx[$clog2(CTL_W)-1:0]] :
                  in_smp ? dac_q[didx[IW-1:0]] : 1'b0;

  wire [SMP_W-1:0] rx_next = {rx_sr[SMP_W-2:0], sd_in};
  wire [CTL_W-1:0] st_next = {sts_sr[CTL_W-2:0], sd_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CW'(NORM_LEN - 1);
      {m_q, w_q, s_q, f_q, mf_q} <= '0;
      ctl_q <= '0;
      dac_q <= '0;
    end else if (sclk_en) begin
      cnt <= boundary ? '0 : cnt + CW'(1);
      if (boundary) begin
        {m_q, w_q, s_q, f_q, mf_q} <= {cfg_mixed, cfg_wide, cfg_s24, cfg_fast, cfg_mfs};
        ctl_q <= ctl_pv ? ctl_p : '0;
        dac_q <= dac_p;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_p  <= '0;
      ctl_pv <= 1'b0;
      dac_p  <= '0;
    end else begin
      if (ctl_valid) begin
        ctl_p  <= ctl_data;
        ctl_pv <= 1'b1;
      end else if (boundary) begin
        ctl_pv <= 1'b0;
      end
      if (dac_valid) dac_p <= dac_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_sr    <= '0;
      rx_sr     <= '0;
      sts_data  <= '0;
      sts_valid <= 1'b0;
      adc_data  <= '0;
      adc_valid <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      sts_valid <= sts_end;
      if (sclk_en && in_ctl) sts_sr <= st_next;
      if (sts_end) sts_data <= st_next;
      if (sclk_en && in_smp) rx_sr <= rx_next;
      if (smp_end) begin
        adc_data  <= s_q ? rx_next : {{(SMP_W-CTL_W){1'b0}}, rx_next[CTL_W-1:0]};
        adc_valid <= 1'b1;
        if (adc_valid && !adc_rd) overrun <= 1'b1;
      end else if (adc_rd) begin
        adc_valid <= 1'b0;
      end
    end
  end

  // R1
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (cnt == '0 && !fs_out));
  // R7
  adc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_valid && !adc_rd && !smp_end) |=> (adc_valid && $stable(adc_data)));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R6
  sts_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> m_q);
  // R8
  ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !ctl_pv) |=> (ctl_q == '0));
endmodule

// File: tb/sim_codec_frame_port.sv
module sim_codec_frame_port;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, sclk_en, cfg_mixed, cfg_wide, cfg_s24, cfg_fast, cfg_mfs;
  logic [15:0] ctl_data, sts_data;
  logic ctl_valid, dac_valid, fs_out, sd_out, sd_in, sts_valid, adc_valid, adc_rd, overrun;
  logic [23:0] dac_data, adc_data;

  codec_frame_port u0 (
    .clk(clk), .rst_n(rst_n), .sclk_en(sclk_en), .cfg_mixed(cfg_mixed), .cfg_wide(cfg_wide),
    .cfg_s24(cfg_s24), .cfg_fast(cfg_fast), .cfg_mfs(cfg_mfs), .ctl_data(ctl_data),
    .ctl_valid(ctl_valid), .dac_data(dac_data), .dac_valid(dac_valid), .fs_out(fs_out),
    .sd_out(sd_out), .sd_in(sd_in), .sts_data(sts_data), .sts_valid(sts_valid),
    .adc_data(adc_data), .adc_valid(adc_valid), .adc_rd(adc_rd), .overrun(overrun));

  int checks = 0, fails = 0;
  int sts_cnt = 0;
  logic [15:0] sts_cap = '0;
  always @(posedge clk) if (sts_valid) begin sts_cap <= sts_data; sts_cnt <= sts_cnt + 1; end

  // bench model state: cfg packed as {mfs, fast, s24, wide, mixed}
  logic [4:0]  cur;
  logic [15:0] ctl_now;
  logic [23:0] dac_now, dac_pend;
  bit unread = 0, ov_exp = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply_cfg(input logic [4:0] c);
    {cfg_mfs, cfg_fast, cfg_s24, cfg_wide, cfg_mixed} = c;
  endtask

  task automatic tick();
    @(negedge clk) sclk_en = 1'b1;
    @(negedge clk) sclk_en = 1'b0;
    repeat ($urandom_range(0, 3)) @(negedge clk);
  endtask

  function automatic bit exp_fs(input logic [4:0] c, input int k);
    int p, g;
    p = c[3] ? 256 : 128;
    g = c[1] ? 32 : 16;
    return (k == p - 1) || (c[4] && (k % g == g - 1));
  endfunction

  function automatic bit exp_bit(input logic [4:0] c, input int k, input logic [15:0] cw, input logic [23:0] dw);
    int g, off, s;
    g = c[1] ? 32 : 16;
    off = c[0] ? g : 0;
    s = c[2] ? 24 : 16;
    if (c[0] && k < 16) return cw[15 - k];
    if (k >= off && k < off + s) return dw[s - 1 - (k - off)];
    return 1'b0;
  endfunction

  task automatic run_frame(input logic [4:0] nxt, input bit mid, input bit do_dac,
                           input bit do_ctl, input bit do_rd);
    int p, g, off, s, berr, ferr, st0, fk, bk;
    logic [15:0] sts_v, new_ctl;
    logic [23:0] adc_v, new_dac;
    string rq;
    bit resend;
    p = cur[3] ? 256 : 128;
    g = cur[1] ? 32 : 16;
    off = cur[0] ? g : 0;
    s = cur[2] ? 24 : 16;
    sts_v = 16'($urandom);
    adc_v = 24'($urandom);
    if (s == 16) adc_v[23:16] = '0;
    new_ctl = 16'($urandom);
    new_dac = 24'($urandom);
    resend = (ctl_now == '0);
    berr = 0; ferr = 0; fk = -1; bk = -1;
    st0 = sts_cnt;
    for (int k = 0; k < p; k++) begin
      if (cur[0] && k < 16) sd_in = sts_v[15 - k];
      else if (k >= off && k < off + s) sd_in = adc_v[s - 1 - (k - off)];
      else sd_in = 1'($urandom);
      if (sd_out !== exp_bit(cur, k, ctl_now, dac_now)) begin berr++; if (bk < 0) bk = k; end
      if (fs_out !== exp_fs(cur, k)) begin ferr++; if (fk < 0) fk = k; end
      if (k == 2) chk(adc_valid === unread, "R7", "adc_valid held before capture", adc_valid, unread);
      if (k == 5) begin
        if (do_dac) begin dac_valid = 1'b1; dac_data = new_dac; end
        if (do_ctl) begin ctl_valid = 1'b1; ctl_data = new_ctl; end
        @(negedge clk);
        dac_valid = 1'b0; ctl_valid = 1'b0;
      end
      if (k == 10 && mid) apply_cfg(nxt);
      if (k == p - 3) begin
        if (unread) ov_exp = 1;
        chk(adc_data === adc_v, "R7", "adc_data", adc_data, adc_v);
        chk(adc_valid === 1'b1, "R7", "adc_valid after capture", adc_valid, 1);
        chk(overrun === ov_exp, "R10", "overrun", overrun, ov_exp);
        if (do_rd) begin
          adc_rd = 1'b1;
          @(negedge clk);
          adc_rd = 1'b0;
        end
      end
      if (k == p - 1) apply_cfg(nxt);
      tick();
    end
    rq = cur[0] ? "R3" : "R4";
    if (cur[2]) rq = {rq, " R5"};
    if (resend) rq = {rq, " R8"};
    if (mid) rq = {rq, " R9"};
    chk(berr == 0, rq, $sformatf("sd_out errors (first slot %0d)", bk), berr, 0);
    chk(ferr == 0, cur[4] ? (mid ? "R2 R9" : "R2") : (mid ? "R1 R9" : "R1"),
        $sformatf("fs_out errors (first slot %0d)", fk), ferr, 0);
    if (cur[0]) begin
      chk(sts_cnt == st0 + 1, "R6", "sts_valid pulses", sts_cnt - st0, 1);
      chk(sts_cap === sts_v, "R6", "sts_data", sts_cap, sts_v);
    end else begin
      chk(sts_cnt == st0, "R4", "no status in data mode", sts_cnt - st0, 0);
    end
    if (do_dac) dac_pend = new_dac;
    dac_now = dac_pend;
    ctl_now = do_ctl ? new_ctl : '0;
    cur = nxt;
    unread = !do_rd;
  endtask

  initial begin
    #(4 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    rst_n = 1'b0; sclk_en = 1'b0; sd_in = 1'b0; adc_rd = 1'b0;
    ctl_valid = 1'b0; dac_valid = 1'b0; ctl_data = '0; dac_data = '0;
    apply_cfg(5'b0);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fs_out === 1'b1, "R1", "reset fs_out in last slot", fs_out, 1);
    chk(sd_out === 1'b0, "R1", "reset sd_out", sd_out, 0);
    chk(adc_valid === 1'b0, "R7", "reset adc_valid", adc_valid, 0);
    chk(overrun === 1'b0, "R10", "reset overrun", overrun, 0);
    chk(sts_valid === 1'b0, "R6", "reset sts_valid", sts_valid, 0);
    // prelude slot: load first words and the first layout
    dac_valid = 1'b1; dac_data = 24'hA5C3F1;
    ctl_valid = 1'b1; ctl_data = 16'h9E27;
    @(negedge clk);
    dac_valid = 1'b0; ctl_valid = 1'b0;
    cur = 5'b00001;
    apply_cfg(cur);
    dac_pend = 24'hA5C3F1; dac_now = dac_pend; ctl_now = 16'h9E27;
    tick();
    // directed frames
    run_frame(5'b00101, 0, 1, 1, 1);  // mixed 16/16 -> mixed 24
    run_frame(5'b01111, 1, 0, 0, 0);  // mixed 24; mid change to fast 32-grid; no read
    run_frame(5'b10010, 0, 1, 0, 1);  // fast mixed 32 24, overrun expected
    run_frame(5'b11110, 1, 0, 0, 1);  // data 16 mfs; mid change
    run_frame(5'b10011, 0, 1, 1, 0);  // data fast 32 24 mfs
    run_frame(5'b00000, 1, 1, 1, 1);  // mixed mfs 32-grid
    run_frame(5'b00001, 0, 0, 0, 1);  // plain data mode, resend
    // random frames
    for (int i = 0; i < 14; i++)
      run_frame(5'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule